// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status

This block watches the already-synchronized input level of every GPIO pin and turns qualifying level or edge conditions into sticky status bits. Each pin has a two-bit trigger code built from a select bit (edge or level) and an invert bit. Together they choose rising edge, falling edge, low level or high level. A pin is watched only while it is in GPIO mode, configured as an input and has input sensing turned on. When any of these drops, the pin's edge history is discarded.

Status and enable bits are held in words of `WORD_W` bits. Pin n sits in word n / `WORD_W` at bit n % `WORD_W`. Software clears status by writing ones, and it replaces a whole enable word with one write. Every bit that is set in both status and enable is pending, and the OR of all pending bits is registered onto a single interrupt line. A routing select for the system interrupt number is not interpreted here; it is passed straight through.

Top module: `gpio_irq_status`

## Requirements
- R1: While reset is high, and on the first cycle after it, every status bit, every enable bit and the interrupt output are 0.
- R2: With trigger code {select,invert} = 00, a pin's status bit becomes 1 on the clock edge that first samples its level high after a sampled low. Once set it stays set when the level returns low.
- R3: With trigger code 01, the status bit is set on the clock edge that samples a high-to-low transition. A low-to-high transition leaves it unchanged.
- R4: With trigger code 10, the status bit is set on every clock edge that samples the level low. With code 11, it is set on every clock edge that samples the level high.
- R5: A write with kind 0 (clear) to word index k clears each status bit of that word whose data bit is 1, and only those bits. Writing all ones clears the whole word. An index with no word behind it (k >= number of words) changes nothing.
- R6: If a trigger event and a clear of the same status bit land on the same clock edge, the bit ends up 1.
- R7: Clearing a level-triggered status bit while its level is still active leaves the bit at 1. Once the level is inactive, a clear takes effect.
- R8: A write with kind 1 (enable) to word index k replaces that enable word with the write data, and enable bits otherwise hold. The interrupt output equals the OR over all pins of (status AND enable) as sampled on the previous clock edge.
- R9: A pin that is not in GPIO mode, not an input, or has sensing off never sets its status bit. After such a pin is re-armed with its level already at the trigger value, no edge is reported until a fresh transition is sampled.
- R10: The routing select output always equals the routing select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level_i | input | NUM_PINS | Synchronized input level per pin |
| trig_sel_i | input | NUM_PINS | Trigger select per pin: 0 edge, 1 level |
| trig_inv_i | input | NUM_PINS | Trigger invert per pin |
| gpio_mode_i | input | NUM_PINS | 1 when the pin is used as GPIO |
| dir_in_i | input | NUM_PINS | 1 when the pin is an input |
| sense_en_i | input | NUM_PINS | 1 when input sensing is on |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_kind_i | input | 1 | 0 clears status bits, 1 loads an enable word |
| wr_idx_i | input | IDX_W | Word index of the write |
| wr_data_i | input | WORD_W | Write data (clear mask or enable word) |
| route_sel_i | input | ROUTE_W | Interrupt routing select, passed through |
| status_o | output | NUM_PINS | Sticky status bits |
| enable_o | output | NUM_PINS | Enable bits |
| route_sel_o | output | ROUTE_W | Copy of route_sel_i |
| irq_o | output | 1 | Registered OR of all pending bits |

## Verification
The bench drives an edge into a bit in the same cycle that software clears it. A design that let the clear win would lose that edge and show a 0. It also clears level-triggered bits while the level is still active and after it has gone away; a design with the priority reversed, or without it, drops the bit in the first case. A pin is re-armed while its level already sits at the trigger value; a design that froze edge history instead of discarding it would report an edge that never happened. The interrupt line is sampled one cycle after enable and status change, so a combinational or two-stage output shows up as a mismatch. A write to the unused fourth word index, and the partial last word at pin 93, catch slips in the word decode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Trigger code is {select, invert}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    typedef enum logic {
        WR_CLEAR  = 1'b0,
        WR_ENABLE = 1'b1
    } wr_kind_e;

    typedef struct packed {
        logic vld;
        logic prev;
    } edge_hist_t;

    function automatic logic is_level_mode(trig_mode_e m);
        return (m == TRIG_LOW) || (m == TRIG_HIGH);
    endfunction

    // Level the pin must show (after an edge, or while held) to trigger
    function automatic logic target_level(trig_mode_e m);
        return (m == TRIG_RISE) || (m == TRIG_HIGH);
    endfunction

    function automatic int words_for(int pins, int width);
        return (pins + width - 1) / width;
    endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    input  logic sel_i,
    input  logic inv_i,
    input  logic armed_i,
    output logic event_o
);

    trig_mode_e mode;
    edge_hist_t hist_q;
    logic       want;
    logic       edge_hit;
    logic       lvl_hit;

    assign mode = trig_mode_e'({sel_i, inv_i});

    // History is dropped whenever the pin is not watched
    always_ff @(posedge clk) begin
        if (rst || !armed_i) begin
            hist_q <= '0;
        end else begin
            hist_q <= '{vld: 1'b1, prev: level_i};
        end
    end

    always_comb begin
        want     = target_level(mode);
        lvl_hit  = (level_i == want);
        edge_hit = hist_q.vld && (hist_q.prev != level_i) && (level_i == want);
        event_o  = armed_i && (is_level_mode(mode) ? lvl_hit : edge_hit);
    end

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word #(
    parameter int WORD_W     = 32,
    parameter int VALID_BITS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] evt_i,
    input  logic              clr_i,
    input  logic              en_wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] status_o,
    output logic [WORD_W-1:0] enable_o
);

    localparam logic [WORD_W-1:0] VALID_MASK = {WORD_W{1'b1}} >> (WORD_W - VALID_BITS);

    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] en_q;
    logic [WORD_W-1:0] clr_mask;

    assign clr_mask = clr_i ? wdata_i : '0;

    // A new event overrides a clear of the same bit
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_mask) | evt_i) & VALID_MASK;
            if (en_wr_i) begin
                en_q <= wdata_i & VALID_MASK;
            end
        end
    end

    assign status_o = stat_q;
    assign enable_o = en_q;

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
#(
    parameter  int NUM_PINS  = 94,
    parameter  int WORD_W    = 32,
    parameter  int ROUTE_W   = 1,
    localparam int NUM_WORDS = words_for(NUM_PINS, WORD_W),
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS + 1) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level_i,
    input  logic [NUM_PINS-1:0] trig_sel_i,
    input  logic [NUM_PINS-1:0] trig_inv_i,
    input  logic [NUM_PINS-1:0] gpio_mode_i,
    input  logic [NUM_PINS-1:0] dir_in_i,
    input  logic [NUM_PINS-1:0] sense_en_i,
    input  logic                wr_en_i,
    input  logic                wr_kind_i,
    input  logic [IDX_W-1:0]    wr_idx_i,
    input  logic [WORD_W-1:0]   wr_data_i,
    input  logic [ROUTE_W-1:0]  route_sel_i,
    output logic [NUM_PINS-1:0] status_o,
    output logic [NUM_PINS-1:0] enable_o,
    output logic [ROUTE_W-1:0]  route_sel_o,
    output logic                irq_o
);

    localparam int PAD_W = NUM_WORDS * WORD_W;

    logic [NUM_PINS-1:0] armed;
    logic [NUM_PINS-1:0] evt;
    logic [PAD_W-1:0]    evt_pad;
    logic [PAD_W-1:0]    stat_pad;
    logic [PAD_W-1:0]    en_pad;
    logic                irq_q;
    wr_kind_e            kind;

    assign armed = gpio_mode_i & dir_in_i & sense_en_i;
    assign kind  = wr_kind_e'(wr_kind_i);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_irq_detect u_det (
            .clk     (clk),
            .rst     (rst),
            .level_i (pin_level_i[p]),
            .sel_i   (trig_sel_i[p]),
            .inv_i   (trig_inv_i[p]),
            .armed_i (armed[p]),
            .event_o (evt[p])
        );
    end

    always_comb begin
        evt_pad                 = '0;
        evt_pad[NUM_PINS-1:0]   = evt;
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int VALID = (w == NUM_WORDS - 1) ? (NUM_PINS - w * WORD_W) : WORD_W;
        logic hit;
        assign hit = wr_en_i && (wr_idx_i == IDX_W'(w));

        gpio_irq_word #(
            .WORD_W     (WORD_W),
            .VALID_BITS (VALID)
        ) u_word (
            .clk      (clk),
            .rst      (rst),
            .evt_i    (evt_pad[w*WORD_W +: WORD_W]),
            .clr_i    (hit && (kind == WR_CLEAR)),
            .en_wr_i  (hit && (kind == WR_ENABLE)),
            .wdata_i  (wr_data_i),
            .status_o (stat_pad[w*WORD_W +: WORD_W]),
            .enable_o (en_pad[w*WORD_W +: WORD_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat_pad & en_pad);
        end
    end

    assign status_o    = stat_pad[NUM_PINS-1:0];
    assign enable_o    = en_pad[NUM_PINS-1:0];
    assign irq_o       = irq_q;
    assign route_sel_o = route_sel_i;

endmodule

// File: rtl/gpio_irq_status_chk.sv
module gpio_irq_status_chk #(
    parameter int NUM_PINS = 94
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] gpio_mode_i,
    input logic [NUM_PINS-1:0] dir_in_i,
    input logic [NUM_PINS-1:0] sense_en_i,
    input logic                wr_en_i,
    input logic                wr_kind_i,
    input logic [NUM_PINS-1:0] status_o,
    input logic [NUM_PINS-1:0] enable_o,
    input logic                irq_o
);

    logic [NUM_PINS-1:0] watched;
    assign watched = gpio_mode_i & dir_in_i & sense_en_i;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (status_o == '0 && enable_o == '0 && !irq_o));

    // R5
    no_silent_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && !wr_kind_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R9
    unwatched_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(watched)) == '0));

    // R8
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && wr_kind_i) |=> $stable(enable_o));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == (|($past(status_o & enable_o)))));

endmodule

bind gpio_irq_status gpio_irq_status_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gpio_mode_i (gpio_mode_i),
    .dir_in_i    (dir_in_i),
    .sense_en_i  (sense_en_i),
    .wr_en_i     (wr_en_i),
    .wr_kind_i   (wr_kind_i),
    .status_o    (status_o),
    .enable_o    (enable_o),
    .irq_o       (irq_o)
);

// File: tb/gpio_irq_status_bench.sv
module gpio_irq_status_bench;

    localparam int NP = 94;
    localparam int WW = 32;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_level = '0;
    logic [NP-1:0] trig_sel  = '0;
    logic [NP-1:0] trig_inv  = '0;
    logic [NP-1:0] gpio_mode = '1;
    logic [NP-1:0] dir_in    = '1;
    logic [NP-1:0] sense_en  = '1;
    logic          wr_en     = 1'b0;
    logic          wr_kind   = 1'b0;
    logic [IW-1:0] wr_idx    = '0;
    logic [WW-1:0] wr_data   = '0;
    logic [0:0]    route_in  = 1'b0;
    logic [NP-1:0] status;
    logic [NP-1:0] enable;
    logic [0:0]    route_out;
    logic          irq;

    always #5 clk = ~clk;

    gpio_irq_status u_gpio_irq_status (
        .clk         (clk),
        .rst         (rst),
        .pin_level_i (pin_level),
        .trig_sel_i  (trig_sel),
        .trig_inv_i  (trig_inv),
        .gpio_mode_i (gpio_mode),
        .dir_in_i    (dir_in),
        .sense_en_i  (sense_en),
        .wr_en_i     (wr_en),
        .wr_kind_i   (wr_kind),
        .wr_idx_i    (wr_idx),
        .wr_data_i   (wr_data),
        .route_sel_i (route_in),
        .status_o    (status),
        .enable_o    (enable),
        .route_sel_o (route_out),
        .irq_o       (irq)
    );

    // Scoreboard queues
    string         q_req[$];
    logic [NP-1:0] q_st[$];
    logic [NP-1:0] q_en[$];
    logic          q_irq[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [NP-1:0] m_st  = '0;
    logic [NP-1:0] m_en  = '0;
    logic          m_irq = 1'b0;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input string req);
        q_req.push_back(req);
        q_st.push_back(m_st);
        q_en.push_back(m_en);
        q_irq.push_back(m_irq);
        @(negedge clk);
    endtask

    task automatic wr_go(input logic kind, input logic [IW-1:0] idx, input logic [WW-1:0] data);
        wr_en   = 1'b1;
        wr_kind = kind;
        wr_idx  = idx;
        wr_data = data;
        step();
        wr_en   = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        while (q_req.size() > 0) begin
            string         r;
            logic [NP-1:0] es;
            logic [NP-1:0] ee;
            logic          ei;
            r  = q_req.pop_front();
            es = q_st.pop_front();
            ee = q_en.pop_front();
            ei = q_irq.pop_front();
            n_cmp++;
            if (status !== es || enable !== ee || irq !== ei) begin
                n_bad++;
                $display("FAIL %s: status=%h exp %h, enable=%h exp %h, irq=%b exp %b",
                         r, status, es, enable, ee, irq, ei);
            end
        end
    end

    initial begin
        // R1: reset state
        step(); step(); step();
        expect_now("R1");
        rst = 1'b0;
        step();
        expect_now("R1");

        // R10: pass-through
        route_in = 1'b1;
        #1;
        n_cmp++;
        if (route_out !== 1'b1) begin
            n_bad++;
            $display("FAIL R10: route=%b exp 1", route_out);
        end

        // R2: rising edge on pin 5
        pin_level[5] = 1'b1;
        step(); m_st[5] = 1'b1;
        expect_now("R2");
        pin_level[5] = 1'b0;
        step();
        expect_now("R2");

        // R3: falling edge on pin 40
        trig_inv[40] = 1'b1;
        step();
        expect_now("R3");
        pin_level[40] = 1'b1;
        step();
        expect_now("R3");
        pin_level[40] = 1'b0;
        step(); m_st[40] = 1'b1;
        expect_now("R3");

        // R4: level high on pin 70, level low on pin 93
        trig_sel[70] = 1'b1; trig_inv[70] = 1'b1;
        step();
        expect_now("R4");
        pin_level[70] = 1'b1;
        step(); m_st[70] = 1'b1;
        expect_now("R4");
        trig_sel[93] = 1'b1;
        step(); m_st[93] = 1'b1;
        expect_now("R4");

        // R5: write-one-to-clear
        wr_go(1'b0, 2'd1, 32'h0000_0100); m_st[40] = 1'b0;
        expect_now("R5");
        wr_go(1'b0, 2'd0, 32'hFFFF_FFFF); m_st[5] = 1'b0;
        expect_now("R5");
        wr_go(1'b0, 2'd3, 32'hFFFF_FFFF);
        expect_now("R5");

        // R7: level bits survive a clear while active
        wr_go(1'b0, 2'd2, 32'hFFFF_FFFF);
        expect_now("R7");
        pin_level[70] = 1'b0;
        step();
        expect_now("R7");
        wr_go(1'b0, 2'd2, 32'h0000_0040); m_st[70] = 1'b0;
        expect_now("R7");

        // R6: edge and clear on the same edge
        pin_level[10] = 1'b1;
        step(); m_st[10] = 1'b1;
        expect_now("R6");
        pin_level[10] = 1'b0;
        step();
        expect_now("R6");
        pin_level[10] = 1'b1;
        wr_go(1'b0, 2'd0, 32'h0000_0400);
        expect_now("R6");
        wr_go(1'b0, 2'd0, 32'h0000_0400); m_st[10] = 1'b0;
        expect_now("R5");

        // R8: enable and registered interrupt
        wr_go(1'b1, 2'd2, 32'h2000_0000); m_en[93] = 1'b1;
        expect_now("R8");
        step(); m_irq = 1'b1;
        expect_now("R8");
        pin_level[93] = 1'b1;
        step();
        expect_now("R8");
        wr_go(1'b0, 2'd2, 32'h2000_0000); m_st[93] = 1'b0;
        expect_now("R8");
        step(); m_irq = 1'b0;
        expect_now("R8");
        wr_go(1'b1, 2'd0, 32'h0000_0400); m_en[10] = 1'b1;
        expect_now("R8");
        step();
        expect_now("R8");

        // R9: unwatched pins and history reset
        sense_en[20]  = 1'b0;
        pin_level[20] = 1'b1;
        step();
        expect_now("R9");
        sense_en[20] = 1'b1;
        step();
        expect_now("R9");
        step();
        expect_now("R9");
        pin_level[20] = 1'b0;
        step();
        pin_level[20] = 1'b1;
        step(); m_st[20] = 1'b1;
        expect_now("R9");
        gpio_mode[21] = 1'b0;
        pin_level[21] = 1'b1;
        step();
        expect_now("R9");
        dir_in[22]   = 1'b0;
        trig_sel[22] = 1'b1; trig_inv[22] = 1'b1;
        pin_level[22] = 1'b1;
        step();
        expect_now("R9");

        step();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run not finished, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule